// File: doc/BRIEF.md
# Key-Guarded Configuration Bank with Complement Integrity Check

This block holds a small bank of configuration registers behind a write guard. After reset the bank is locked. Writes to a configuration address take effect only while the guard is open. Software opens the guard by writing a two-value key to a dedicated unlock address. The guard then stays open for a fixed number of cycles, or until one configuration write has been accepted, whichever comes first. After that it closes again on its own.

Each configuration register is stored twice: once as its true value and once as a bitwise inverted shadow. Both copies are loaded in the same cycle. A comparator runs every cycle and looks for any bit position where the two copies agree. Such a position means the pair is no longer complementary, and the comparator then sets a sticky integrity error. An upset that pushes every bit of a register toward one level leaves both copies equal, so the comparator always catches it. The `upset_i`/`upset_lvl_i` inputs model such a disturbance, so the detection path can be exercised.

Top module: `cfglock_top`

## Requirements
- R1: After reset every register reads 0 on `cfg_o`, with its shadow holding all ones. `locked_o` is 1 and `integ_err_o` is 0.
- R2: While `locked_o` is 1, a write to a configuration address (0 to NREG-1) leaves `cfg_o` unchanged.
- R3: The guard opens when the value 0x55 is written to the unlock address (address NREG) and the next write is 0xAA to that same address. Idle cycles may separate the two writes. `locked_o` falls in the cycle after the 0xAA write.
- R4: Any other write between the two key writes cancels the sequence. This covers a write to another address and a write of another value. A 0xAA write with no 0x55 just before it does not open the guard.
- R5: With no configuration write, the guard stays open for exactly WIN (16) cycles after the 0xAA write. A write presented in any of those cycles is accepted. `locked_o` is 1 again from the cycle after the last of them.
- R6: An accepted configuration write closes the guard. `locked_o` is 1 in the next cycle, so a second write is rejected.
- R7: An accepted write to address r appears on `cfg_o[r*DW +: DW]` in the next cycle. A write to an address above NREG changes no register and does not close an open guard.
- R8: When `upset_i[r]` is high, both copies of register r are forced to all `upset_lvl_i` at the next edge. `integ_err_o` then rises one cycle later.
- R9: `integ_err_o` stays high until `err_clr_i` is asserted in a cycle where every register pair is complementary. A clear is ignored while any pair is still corrupt. Rewriting a register through an open guard restores its pair.
- R10: If an upset and an accepted write hit the same register in the same cycle, the upset wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | AW | Write address: 0..NREG-1 configuration, NREG unlock |
| wr_data_i | input | DW | Write data |
| err_clr_i | input | 1 | Request to clear the integrity error |
| upset_i | input | NREG | Disturbance model, one bit per register |
| upset_lvl_i | input | 1 | Level that a disturbance forces |
| cfg_o | output | NREG*DW | True values of all registers, register 0 in the low bits |
| locked_o | output | 1 | 1 while configuration writes are blocked |
| integ_err_o | output | 1 | Sticky integrity error |

## Verification
The assertions assume three things about the inputs. NREG+1 fits in the address width. Key values fit in DW. No upset arrives in the same cycle that the property under test relies on a quiet bank: the lock-holds-value property excludes upset cycles explicitly. Random stimulus picks addresses only from the legal range. Upsets are kept rare, so windows and repairs occur between them. A bench reference model tracks the key state, the window count, the corrupt pairs and the sticky error, and the outputs are compared with it every cycle.

// File: rtl/cfglock_pkg.sv
package cfglock_pkg;
    localparam logic [7:0] KEY_OPEN_A = 8'h55;
    localparam logic [7:0] KEY_OPEN_B = 8'hAA;

    typedef enum logic {
        KS_IDLE  = 1'b0,
        KS_ARMED = 1'b1
    } key_state_e;
endpackage

// File: rtl/cfglock_keyseq.sv
module cfglock_keyseq
    import cfglock_pkg::*;
#(
    parameter int NREG = 4,
    parameter int DW   = 8,
    parameter int AW   = 3,
    parameter int WIN  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          cfg_acc_i,
    output logic          open_o
);
    localparam int          CW       = $clog2(WIN + 1);
    localparam logic [AW-1:0] UNLK_ADR = AW'(NREG);

    typedef struct packed {
        key_state_e    st;
        logic [CW-1:0] cnt;
    } ks_t;

    ks_t ks_d, ks_q;
    logic key_hit, key_done;

    always_comb begin
        ks_d     = ks_q;
        key_hit  = wr_en_i && (wr_addr_i == UNLK_ADR);
        key_done = key_hit && (wr_data_i == DW'(KEY_OPEN_B)) && (ks_q.st == KS_ARMED);
        if (wr_en_i) begin
            ks_d.st = (key_hit && (wr_data_i == DW'(KEY_OPEN_A))) ? KS_ARMED : KS_IDLE;
        end
        if (cfg_acc_i) begin
            ks_d.cnt = '0;
        end else if (key_done) begin
            ks_d.cnt = CW'(WIN);
        end else if (ks_q.cnt != '0) begin
            ks_d.cnt = ks_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ks_q <= '{st: KS_IDLE, cnt: '0};
        end else begin
            ks_q <= ks_d;
        end
    end

    assign open_o = (ks_q.cnt != '0);
endmodule

// File: rtl/cfglock_bank.sv
module cfglock_bank #(
    parameter int NREG = 4,
    parameter int DW   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NREG-1:0]    we_i,
    input  logic [DW-1:0]      wdata_i,
    input  logic [NREG-1:0]    upset_i,
    input  logic               upset_lvl_i,
    output logic [NREG*DW-1:0] val_o,
    output logic [NREG-1:0]    bad_o
);
    typedef struct packed {
        logic [DW-1:0] tv;
        logic [DW-1:0] sv;
    } pair_t;

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        pair_t p_d, p_q;

        always_comb begin
            p_d = p_q;
            if (upset_i[r]) begin
                p_d.tv = {DW{upset_lvl_i}};
                p_d.sv = {DW{upset_lvl_i}};
            end else if (we_i[r]) begin
                p_d.tv = wdata_i;
                p_d.sv = ~wdata_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                p_q <= '{tv: '0, sv: '1};
            end else begin
                p_q <= p_d;
            end
        end

        assign val_o[r*DW +: DW] = p_q.tv;
        assign bad_o[r]          = |(~(p_q.tv ^ p_q.sv));
    end
endmodule

// File: rtl/cfglock_top.sv
module cfglock_top #(
    parameter int NREG = 4,
    parameter int DW   = 8,
    parameter int AW   = 3,
    parameter int WIN  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [AW-1:0]      wr_addr_i,
    input  logic [DW-1:0]      wr_data_i,
    input  logic               err_clr_i,
    input  logic [NREG-1:0]    upset_i,
    input  logic               upset_lvl_i,
    output logic [NREG*DW-1:0] cfg_o,
    output logic               locked_o,
    output logic               integ_err_o
);
    logic            open_w, cfg_hit, cfg_acc;
    logic [NREG-1:0] we_w, bad_w;
    logic            err_d, err_q;

    assign cfg_hit = wr_en_i && (wr_addr_i < AW'(NREG));
    assign cfg_acc = cfg_hit && open_w;

    for (genvar r = 0; r < NREG; r++) begin : g_dec
        assign we_w[r] = cfg_acc && (wr_addr_i == AW'(r));
    end

    cfglock_keyseq #(.NREG(NREG), .DW(DW), .AW(AW), .WIN(WIN)) u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .cfg_acc_i (cfg_acc),
        .open_o    (open_w)
    );

    cfglock_bank #(.NREG(NREG), .DW(DW)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (we_w),
        .wdata_i     (wr_data_i),
        .upset_i     (upset_i),
        .upset_lvl_i (upset_lvl_i),
        .val_o       (cfg_o),
        .bad_o       (bad_w)
    );

    always_comb begin
        err_d = (err_q && !err_clr_i) || (|bad_w);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= err_d;
        end
    end

    assign locked_o    = !open_w;
    assign integ_err_o = err_q;
endmodule

// File: rtl/cfglock_chk.sv
module cfglock_chk #(
    parameter int NREG = 4,
    parameter int DW   = 8,
    parameter int AW   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en_i,
    input logic [AW-1:0]      wr_addr_i,
    input logic               err_clr_i,
    input logic [NREG-1:0]    upset_i,
    input logic               upset_lvl_i,
    input logic [NREG*DW-1:0] cfg_o,
    input logic               locked_o,
    input logic               integ_err_o
);
    AST_LOCKED_HOLDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && !(|upset_i)) |=> $stable(cfg_o)); // R2

    AST_IDLE_STAYS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && !wr_en_i) |=> locked_o); // R3

    AST_WRITE_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked_o && wr_en_i && (wr_addr_i < AW'(NREG))) |=> locked_o); // R6

    AST_UPSET_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (|upset_i) |=> ##1 integ_err_o); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (integ_err_o && !err_clr_i) |=> integ_err_o); // R9

    for (genvar r = 0; r < NREG; r++) begin : g_up
        AST_UPSET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            upset_i[r] |=> (cfg_o[r*DW +: DW] == {DW{$past(upset_lvl_i)}})); // R10
    end
endmodule

bind cfglock_top cfglock_chk #(.NREG(NREG), .DW(DW), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .err_clr_i   (err_clr_i),
    .upset_i     (upset_i),
    .upset_lvl_i (upset_lvl_i),
    .cfg_o       (cfg_o),
    .locked_o    (locked_o),
    .integ_err_o (integ_err_o)
);

// File: tb/sim_cfglock_top.sv
module sim_cfglock_top;
    localparam int PER  = 10;
    localparam int NREG = 4;
    localparam int DW   = 8;
    localparam int AW   = 3;
    localparam int WIN  = 16;
    localparam logic [AW-1:0] UNLK = AW'(NREG);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en_i = 1'b0;
    logic [AW-1:0]      wr_addr_i = '0;
    logic [DW-1:0]      wr_data_i = '0;
    logic               err_clr_i = 1'b0;
    logic [NREG-1:0]    upset_i = '0;
    logic               upset_lvl_i = 1'b0;
    logic [NREG*DW-1:0] cfg_o;
    logic               locked_o;
    logic               integ_err_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [DW-1:0] m_cfg [NREG];
    logic          m_bad [NREG];
    logic          m_armed;
    int            m_cnt;
    logic          m_err;

    always #(PER/2) clk = ~clk;

    cfglock_top #(.NREG(NREG), .DW(DW), .AW(AW), .WIN(WIN)) u0 (.*);

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [NREG*DW-1:0] exp_cfg();
        logic [NREG*DW-1:0] v;
        for (int r = 0; r < NREG; r++) v[r*DW +: DW] = m_cfg[r];
        return v;
    endfunction

    task automatic compare_all(string tag);
        check(tag, "cfg_o", 64'(cfg_o), 64'(exp_cfg()));
        check(tag, "locked_o", 64'(locked_o), 64'(m_cnt == 0));
        check(tag, "integ_err_o", 64'(integ_err_o), 64'(m_err));
    endtask

    task automatic step(string tag, bit en, logic [AW-1:0] a, logic [DW-1:0] d,
                        logic [NREG-1:0] up, bit lvl, bit clr);
        bit any_bad, acc, khit, kdone;
        @(negedge clk);
        wr_en_i = en; wr_addr_i = a; wr_data_i = d;
        upset_i = up; upset_lvl_i = lvl; err_clr_i = clr;
        @(posedge clk);
        any_bad = 1'b0;
        for (int r = 0; r < NREG; r++) any_bad |= m_bad[r];
        acc   = en && (a < UNLK) && (m_cnt != 0);
        khit  = en && (a == UNLK);
        kdone = khit && (d == 8'hAA) && m_armed;
        m_err = (m_err && !clr) || any_bad;
        for (int r = 0; r < NREG; r++) begin
            if (up[r]) begin
                m_cfg[r] = {DW{lvl}}; m_bad[r] = 1'b1;
            end else if (acc && a == AW'(r)) begin
                m_cfg[r] = d; m_bad[r] = 1'b0;
            end
        end
        if (en) m_armed = khit && (d == 8'h55);
        if (acc) m_cnt = 0;
        else if (kdone) m_cnt = WIN;
        else if (m_cnt != 0) m_cnt--;
        #(PER/4);
        compare_all(tag);
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 0, '0, '0, '0, 0, 0);
    endtask

    task automatic wr(string tag, logic [AW-1:0] a, logic [DW-1:0] d);
        step(tag, 1, a, d, '0, 0, 0);
    endtask

    task automatic unlock(string tag);
        wr(tag, UNLK, 8'h55);
        wr(tag, UNLK, 8'hAA);
    endtask

    initial begin
        #(PER * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        for (int r = 0; r < NREG; r++) begin m_cfg[r] = '0; m_bad[r] = 1'b0; end
        m_armed = 1'b0; m_cnt = 0; m_err = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        compare_all("R1");

        // R2 locked writes have no effect
        wr("R2", 0, 8'h5A); wr("R2", 3, 8'hFF); idle("R2", 2);

        // R3 unlock, then R7 write lands
        unlock("R3"); wr("R7", 1, 8'h3C); idle("R7", 1);
        // R3 idle cycles between the key writes are allowed
        wr("R3", UNLK, 8'h55); idle("R3", 3); wr("R3", UNLK, 8'hAA); wr("R3", 2, 8'h81);

        // R6 one write closes the window
        unlock("R6"); wr("R6", 2, 8'h11); wr("R6", 3, 8'h22); idle("R6", 1);

        // R4 broken sequences
        wr("R4", UNLK, 8'h55); wr("R4", 0, 8'h77); wr("R4", UNLK, 8'hAA); wr("R4", 0, 8'h77);
        wr("R4", UNLK, 8'hAA); wr("R4", 0, 8'h78);
        wr("R4", UNLK, 8'h55); wr("R4", UNLK, 8'h12); wr("R4", UNLK, 8'hAA); wr("R4", 0, 8'h79);
        wr("R4", UNLK, 8'h55); wr("R4", 6, 8'h00); wr("R4", UNLK, 8'hAA); wr("R4", 1, 8'h7A);

        // R5 last open cycle accepts, the one after rejects
        unlock("R5"); idle("R5", WIN - 1); wr("R5", 3, 8'hC3);
        unlock("R5"); idle("R5", WIN); wr("R5", 3, 8'h99); idle("R5", 1);

        // R7 write above unlock address ignored and keeps window open
        unlock("R7"); wr("R7", 6, 8'hEE); wr("R7", 7, 8'hEF); wr("R7", 0, 8'h42);

        // R8 upsets toward ones and zeros
        step("R8", 0, '0, '0, 4'b0100, 1, 0); idle("R8", 2);
        step("R8", 0, '0, '0, 4'b0010, 0, 0); idle("R8", 2);

        // R9 clear ignored while corrupt; repair then clear
        step("R9", 0, '0, '0, '0, 0, 1); idle("R9", 1);
        unlock("R9"); wr("R9", 2, 8'h0F);
        step("R9", 0, '0, '0, '0, 0, 1);
        unlock("R9"); wr("R9", 1, 8'hF0);
        idle("R9", 1);
        step("R9", 0, '0, '0, '0, 0, 1); idle("R9", 2);

        // R10 upset beats a simultaneous accepted write
        unlock("R10"); step("R10", 1, 0, 8'h66, 4'b0001, 0, 0); idle("R10", 2);
        unlock("R10"); wr("R10", 0, 8'h66); step("R10", 0, '0, '0, '0, 0, 1); idle("R10", 1);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int op;
            logic [NREG-1:0] up;
            bit en, clr;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            op = $urandom_range(0, 9);
            en = 1'b1; a = UNLK; d = $urandom();
            case (op)
                0, 1: d = 8'h55;
                2:    d = 8'hAA;
                3, 4, 5: a = AW'($urandom_range(0, NREG - 1));
                6:    ;
                7:    a = AW'($urandom_range(NREG + 1, 7));
                default: en = 1'b0;
            endcase
            up = ($urandom_range(0, 39) == 0) ? NREG'(1 << $urandom_range(0, NREG - 1)) : '0;
            clr = ($urandom_range(0, 7) == 0);
            step("RND", en, a, d, up, $urandom_range(0, 1), clr);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule